// File: doc/BRIEF.md
# Chip Select Unit with Wait States

This block sits beside a processor on a 24-bit address bus. It turns each bus cycle into one of two active-low chip selects and paces the cycle with a data-transfer acknowledge. Each channel has its own window (base address plus a power-of-two block length), its own read and write permission, and its own wait-state count. A select is driven only while the address strobe is active, the address lies in the window and the access direction is allowed. The acknowledge follows after the channel's wait states.

The settings of each channel sit in a small register set that a simple write port loads, one field per write. On reset the registers take their defaults. Channel 0 covers a 128 KiB window from 0x40000 with no wait states. Channel 1 covers a 2 KiB window from 0x60000 with two wait states. Both default channels serve an 8-bit device that accepts reads and writes. Steering of byte lanes, arbitration and the devices themselves lie outside the block.

Top module: `csu_top`

## Requirements
- R1: After reset, an active strobe with an address from 0x40000 to 0x5FFFF drives cs_n = 2'b10 (cs_n[0] low), for both reads and writes.
- R2: After reset, an active strobe with an address from 0x60000 to 0x607FF drives cs_n = 2'b01 (cs_n[1] low), for both reads and writes.
- R3: An address outside every window leaves cs_n = 2'b11 and dtack_n high for the whole cycle.
- R4: While as_n is high, cs_n stays 2'b11, even when the address lies inside a window.
- R5: dtack_n goes low once W+1 rising edges have been seen with the strobe active, where W is the selected channel's wait count. It goes high in the same cycle that as_n returns high and stays high.
- R6: The permission field holds bit 0 = reads allowed and bit 1 = writes allowed. rd_wr = 1 marks a read. An access in a forbidden direction drives no chip select and no acknowledge.
- R7: At most one chip select is low at any time. When an address lies in several windows, the lowest-numbered hit channel wins, even when its permission then forbids the access.
- R8: The default wait count is 0 for channel 0 and 2 for channel 1. A programmed count changes the acknowledge delay to match R5.
- R9: Reset (rst_n low at a rising edge) restores every channel's default base, length, permission and wait count.
- R10: When cfg_we is high at a rising edge, the field of channel cfg_ch named by cfg_fld is loaded from cfg_wdata. The field codes are 0 = base address, 1 = log2 of block length (low 5 bits), 2 = permission (low 2 bits) and 3 = wait count (low 4 bits). The new value applies from the next bus cycle on.
- R11: Decoding compares only the address bits at and above log2 of the block length. Widening channel 1 to 4 KiB (log2 = 12) makes 0x60FFF hit, while 0x61000 still misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 24 | Processor address bus |
| as_n | input | 1 | Address strobe, active low |
| rd_wr | input | 1 | Direction, 1 = read, 0 = write |
| cfg_we | input | 1 | Configuration write enable |
| cfg_ch | input | 1 | Channel targeted by the configuration write |
| cfg_fld | input | 2 | Field code of the configuration write |
| cfg_wdata | input | 24 | Configuration write data |
| cs_n | output | 2 | Chip selects, active low, one per channel |
| dtack_n | output | 1 | Data-transfer acknowledge, active low |

## Verification
The chip selects are combinational, so they are valid within the same cycle in which the strobe and address are driven. The acknowledge is registered and appears after the (W+1)th rising edge that sees the strobe, counting that first edge as edge 0 of the cycle. The bench drives inputs on falling edges and samples 5 ns after each rising edge. It numbers those samples from 0 within each bus cycle, so the expected acknowledge index is exactly W+1. When the strobe drops, the first sample taken with the strobe high closes the cycle. At that point the scoreboard compares the recorded select pattern and acknowledge index against the queued expectation and checks that the acknowledge has already been released.

// File: rtl/csu_pkg.sv
`timescale 1ns/1ps
// Package csu_pkg
// Shared widths, the per-channel configuration record and the reset
// defaults of the chip select unit. Assumes at most a handful of channels.
package csu_pkg;

    parameter int CSU_ADDR_W = 24;
    parameter int CSU_LEN_W  = 5;
    parameter int CSU_WAIT_W = 4;

    typedef struct packed {
        logic [CSU_ADDR_W-1:0] base;
        logic [CSU_LEN_W-1:0]  size_lg;
        logic                  rd_ok;
        logic                  wr_ok;
        logic [CSU_WAIT_W-1:0] waits;
    } csu_chan_t;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_SIZE = 2'd1,
        FLD_PERM = 2'd2,
        FLD_WAIT = 2'd3
    } csu_field_e;

    // Reset value for one channel; channels past 1 come up disabled.
    function automatic csu_chan_t csu_reset_cfg(input int ch);
        csu_chan_t c;
        c = '0;
        case (ch)
            0: begin
                c.base    = CSU_ADDR_W'(32'h0004_0000);
                c.size_lg = CSU_LEN_W'(17);
                c.rd_ok   = 1'b1;
                c.wr_ok   = 1'b1;
                c.waits   = CSU_WAIT_W'(0);
            end
            1: begin
                c.base    = CSU_ADDR_W'(32'h0006_0000);
                c.size_lg = CSU_LEN_W'(11);
                c.rd_ok   = 1'b1;
                c.wr_ok   = 1'b1;
                c.waits   = CSU_WAIT_W'(2);
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/csu_cfg_regs.sv
`timescale 1ns/1ps
// Module csu_cfg_regs
// Holds the configuration record of every channel. One field of one
// channel is loaded per write; reset restores the package defaults.
// Assumes cfg_ch never names a channel beyond NUM_CH-1 (such writes are dropped).
module csu_cfg_regs
    import csu_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CH_W-1:0]              wr_ch,
    input  logic [1:0]                   wr_fld,
    input  logic [CSU_ADDR_W-1:0]        wr_data,
    output csu_chan_t [NUM_CH-1:0]       cfg
);

    csu_chan_t [NUM_CH-1:0] cfg_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        // Load defaults on reset, else update the addressed field.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[g] <= csu_reset_cfg(g);
            end else if (wr_en && wr_ch == CH_W'(g)) begin
                case (csu_field_e'(wr_fld))
                    FLD_BASE: cfg_q[g].base    <= wr_data;
                    FLD_SIZE: cfg_q[g].size_lg <= wr_data[CSU_LEN_W-1:0];
                    FLD_PERM: begin
                        cfg_q[g].rd_ok <= wr_data[0];
                        cfg_q[g].wr_ok <= wr_data[1];
                    end
                    FLD_WAIT: cfg_q[g].waits   <= wr_data[CSU_WAIT_W-1:0];
                    default:  cfg_q[g].waits   <= cfg_q[g].waits;
                endcase
            end
        end

        // R10
        wait_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_ch == CH_W'(g) && wr_fld == 2'd3)
            |=> (cfg_q[g].waits == $past(wr_data[CSU_WAIT_W-1:0])));

        // R10
        cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en) |=> $stable(cfg_q[g]));
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/csu_window.sv
`timescale 1ns/1ps
// Module csu_window
// Combinational window match for one channel: compares the address with
// the base above the block-size boundary and applies the direction permission.
// Assumes the block length is a power of two; base bits below it are ignored.
module csu_window
    import csu_pkg::*;
(
    input  logic [CSU_ADDR_W-1:0] addr,
    input  logic                  rd,
    input  logic [CSU_ADDR_W-1:0] base,
    input  logic [CSU_LEN_W-1:0]  size_lg,
    input  logic                  rd_ok,
    input  logic                  wr_ok,
    output logic                  hit,
    output logic                  ok
);

    logic [CSU_ADDR_W-1:0] keep_mask;

    // Build the mask of address bits that take part in the compare.
    always_comb begin
        for (int b = 0; b < CSU_ADDR_W; b++) begin
            keep_mask[b] = (b >= int'(size_lg));
        end
    end

    // Window hit and permitted access for this channel.
    always_comb begin
        hit = (((addr ^ base) & keep_mask) == '0);
        ok  = hit && (rd ? rd_ok : wr_ok);
    end

endmodule

// File: rtl/csu_wait_ctr.sv
`timescale 1ns/1ps
// Module csu_wait_ctr
// Paces one bus cycle: loads the selected wait count on the first edge that
// sees a selected strobe, counts it down, then raises ack until the strobe
// ends. Assumes the selection is stable for the life of the strobe.
module csu_wait_ctr
    import csu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe,
    input  logic                  sel_any,
    input  logic [CSU_WAIT_W-1:0] wait_load,
    output logic                  ack
);

    typedef enum logic [1:0] {
        WC_IDLE  = 2'd0,
        WC_COUNT = 2'd1,
        WC_DONE  = 2'd2
    } wc_state_e;

    wc_state_e             st;
    logic [CSU_WAIT_W-1:0] cnt;

    // Cycle sequencer: idle, count wait states, hold acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= WC_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                WC_IDLE: begin
                    if (strobe && sel_any) begin
                        st  <= WC_COUNT;
                        cnt <= wait_load;
                    end
                end
                WC_COUNT: begin
                    if (!strobe) begin
                        st <= WC_IDLE;
                    end else if (cnt == '0) begin
                        st <= WC_DONE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                WC_DONE: begin
                    if (!strobe) begin
                        st <= WC_IDLE;
                    end
                end
                default: st <= WC_IDLE;
            endcase
        end
    end

    assign ack = (st == WC_DONE);

    // R8
    no_early_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WC_COUNT && cnt != '0) |=> !ack);

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WC_COUNT && cnt != '0 && strobe) |=> (cnt == $past(cnt) - 1'b1));

    // R5
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe) |=> !ack);

    // R5
    ack_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(st == WC_COUNT && cnt == '0));

endmodule

// File: rtl/csu_top.sv
`timescale 1ns/1ps
// Module csu_top
// Chip select unit: per-channel window decode with permission, lowest-index
// priority, strobe gating of the selects and a wait-state paced acknowledge.
// Assumes address and direction are stable while as_n is low.
module csu_top
    import csu_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CSU_ADDR_W-1:0] addr,
    input  logic                  as_n,
    input  logic                  rd_wr,
    input  logic                  cfg_we,
    input  logic [CH_W-1:0]       cfg_ch,
    input  logic [1:0]            cfg_fld,
    input  logic [CSU_ADDR_W-1:0] cfg_wdata,
    output logic [NUM_CH-1:0]     cs_n,
    output logic                  dtack_n
);

    csu_chan_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]      hit;
    logic [NUM_CH-1:0]      ok;
    logic [NUM_CH-1:0]      grant;
    logic [CSU_WAIT_W-1:0]  wait_sel;
    logic                   strobe;
    logic                   ack;

    assign strobe = !as_n;

    csu_cfg_regs #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_ch   (cfg_ch),
        .wr_fld  (cfg_fld),
        .wr_data (cfg_wdata),
        .cfg     (cfg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_win
        csu_window u_win (
            .addr    (addr),
            .rd      (rd_wr),
            .base    (cfg[g].base),
            .size_lg (cfg[g].size_lg),
            .rd_ok   (cfg[g].rd_ok),
            .wr_ok   (cfg[g].wr_ok),
            .hit     (hit[g]),
            .ok      (ok[g])
        );
    end

    // Lowest hit channel owns the address; it is granted only if permitted.
    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            grant[i] = ok[i] && !taken;
            taken    = taken || hit[i];
        end
    end

    // Wait count of the granted channel.
    always_comb begin
        wait_sel = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (grant[i]) begin
                wait_sel = cfg[i].waits;
            end
        end
    end

    csu_wait_ctr u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .sel_any   (|grant),
        .wait_load (wait_sel),
        .ack       (ack)
    );

    // Drive the active-low outputs, both qualified by the strobe.
    always_comb begin
        cs_n    = ~(grant & {NUM_CH{strobe}});
        dtack_n = !(ack && strobe);
    end

    // R7
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R4
    cs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (&cs_n));

    // R6
    ack_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n) |-> !(&cs_n));

    // R7
    prio_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && strobe) |-> (&cs_n[NUM_CH-1:1]));

endmodule

// File: tb/sim_csu_top.sv
`timescale 1ns/1ps
module sim_csu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        as_n = 1'b1;
    logic        rd_wr = 1'b1;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_ch = '0;
    logic [1:0]  cfg_fld = '0;
    logic [23:0] cfg_wdata = '0;
    logic [1:0]  cs_n;
    logic        dtack_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int    exp_cs_q[$];
    int    exp_ack_q[$];
    string tag_q[$];

    localparam int HOLD = 10;

    always #10 clk = ~clk;

    csu_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .as_n      (as_n),
        .rd_wr     (rd_wr),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_fld   (cfg_fld),
        .cfg_wdata (cfg_wdata),
        .cs_n      (cs_n),
        .dtack_n   (dtack_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int ch, input int fld, input int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_ch    = 1'(ch);
        cfg_fld   = 2'(fld);
        cfg_wdata = 24'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Driver: one strobed bus cycle plus the expected outcome.
    task automatic bus_cycle(input int a, input bit rd, input int exp_cs,
                             input int exp_ack, input string tag);
        @(negedge clk);
        addr  = 24'(a);
        rd_wr = rd;
        as_n  = 1'b0;
        exp_cs_q.push_back(exp_cs);
        exp_ack_q.push_back(exp_ack);
        tag_q.push_back(tag);
        repeat (HOLD) @(negedge clk);
        as_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: samples 5 ns after each rising edge and scores each cycle.
    initial begin
        bit     active = 0;
        int     idx = 0;
        int     got_cs = 3;
        int     ack_idx = -1;
        forever begin
            @(posedge clk);
            #5;
            if (!rst_n) begin
                active = 0;
            end else if (!as_n) begin
                if (!active) begin
                    active  = 1;
                    idx     = 0;
                    got_cs  = int'(cs_n);
                    ack_idx = -1;
                end else begin
                    idx++;
                end
                if (!dtack_n && ack_idx < 0) ack_idx = idx;
            end else if (active) begin
                string t;
                active = 0;
                if (tag_q.size() == 0) begin
                    check("scoreboard underflow", 1, 0);
                end else begin
                    t = tag_q.pop_front();
                    check({t, " cs_n"}, got_cs, exp_cs_q.pop_front());
                    check({t, " ack index"}, ack_idx, exp_ack_q.pop_front());
                    // R5: acknowledge released once the strobe is high
                    check({t, " R5 release"}, int'(dtack_n), 1);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state of the outputs
        check("R9 reset cs_n", int'(cs_n), 3);
        check("R9 reset dtack_n", int'(dtack_n), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: in-window address without strobe
        addr = 24'h040000;
        #2;
        check("R4 no strobe cs_n", int'(cs_n), 3);
        addr = 24'h060010;
        @(posedge clk);
        #5;
        check("R4 no strobe cs_n ch1", int'(cs_n), 3);
        check("R4 no strobe dtack_n", int'(dtack_n), 1);

        // R1/R2/R5/R8: default windows and wait counts
        bus_cycle(32'h40000, 1, 2, 1, "R1 ch0 low read");
        bus_cycle(32'h5FFFF, 0, 2, 1, "R1 ch0 top write");
        bus_cycle(32'h60000, 1, 1, 3, "R2 R8 ch1 low read");
        bus_cycle(32'h607FF, 0, 1, 3, "R2 ch1 top write");
        // R3: misses
        bus_cycle(32'h60800, 1, 3, -1, "R3 above ch1");
        bus_cycle(32'h3FFFF, 0, 3, -1, "R3 below ch0");

        // R11/R10: widen channel 1 to 4 KiB
        cfg_write(1, 1, 12);
        bus_cycle(32'h60FFF, 1, 1, 3, "R11 widened hit");
        bus_cycle(32'h61000, 1, 3, -1, "R11 widened miss");

        // R6: channel 1 read only
        cfg_write(1, 2, 1);
        bus_cycle(32'h60000, 0, 3, -1, "R6 write forbidden");
        bus_cycle(32'h60004, 1, 1, 3, "R6 read allowed");

        // R8/R10: channel 0 with five wait states
        cfg_write(0, 3, 5);
        bus_cycle(32'h40010, 1, 2, 6, "R8 R10 ch0 wait5");

        // R7: overlapping windows, channel 0 wins
        cfg_write(1, 0, 32'h40000);
        bus_cycle(32'h40000, 1, 2, 6, "R7 overlap ch0 wins");
        cfg_write(0, 2, 2);
        bus_cycle(32'h40000, 1, 3, -1, "R7 ch0 hit forbids ch1");

        // R9: reset restores every default
        pulse_reset();
        bus_cycle(32'h60000, 0, 1, 3, "R9 ch1 default");
        bus_cycle(32'h40000, 1, 2, 1, "R9 ch0 default");
        bus_cycle(32'h607FF, 1, 1, 3, "R9 ch1 size default");
        bus_cycle(32'h60800, 1, 3, -1, "R9 ch1 miss default");

        repeat (4) @(negedge clk);
        check("queue drained", tag_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule